// File: doc/BRIEF.md
# Converter Power-Up Initialization Sequencer

This block lives on the host side of a high-speed data converter. It brings the converter out of power-up in a fixed order. It waits for the supplies to be good. It times a power-on delay and holds off until the converter's system reference clock is running. It then drives a single active-high reset pulse and leaves a short gap before any serial access. After that it hands six numbered register-write groups, one at a time, to an external serial-register writer.

The writer receives a group index and a one-cycle start strobe. It answers with a one-cycle completion pulse. Between the second interleave-calibration group and the first nonlinearity group, the sequencer inserts a long settle pause so that the converter can estimate its interleaving errors. Every minimum time is a cycle count, rounded up from the clock-frequency parameter. A writer that stays silent past a cycle budget leaves the sequencer in a sticky fault. If the supplies drop at any time, the sequencer goes back to idle.

Cycle counts are ceil(t × CLK_HZ / 1e9) for t in ns: PWR = 1 ms, RST = 1 µs, GAP = 100 ns, SETTLE = 50 ms. TMO is the parameter TMO_CYC.

Top module: `conv_boot_seq`

## Requirements
- R1: After rstN is released, convReset, grpStart, seqDone and seqFault are all 0. seqFault is cleared only by rstN.
- R2: With sysrefOk already high, convReset rises exactly PWR+1 cycles after the first clock edge that samples suppliesOk high.
- R3: Once convReset has risen, it stays high for exactly RST+1 cycles and then returns low. This gives one low-high-low pulse.
- R4: The first grpStart rises exactly GAP+1 cycles after convReset falls. GAP is rounded up, so 100 ns never becomes 0 cycles.
- R5: convReset never rises while sysrefOk is low. If the power-on delay has already expired, convReset rises on the edge that first samples sysrefOk high.
- R6: The groups are started in index order 0 to 5: 0 = analog trim, 1 = interleave calibration channel A, 2 = interleave calibration channel B, 3 = nonlinearity channel A, 4 = nonlinearity channel B, 5 = link and down-converter configuration. grpStart is high for one cycle, and grpIdx is valid while it is high.
- R7: Group 3 starts exactly SETTLE+1 cycles after the edge that accepts completion of group 2. Every other group starts on the same edge that accepts completion of the previous group.
- R8: After completion of group 5 is accepted, seqDone is 1 from the next cycle onward and convReset stays 0.
- R9: groupDone is accepted on the edges from 2 to TMO+1 cycles after the grpStart rise, and this includes the expiry edge itself. If it is absent on edge TMO+1, seqFault rises on that edge.
- R10: While seqFault is set, no grpStart or reset pulse is issued, even if suppliesOk is cycled.
- R11: On the cycle after suppliesOk is sampled low, convReset, grpStart and seqDone are 0. When supplies return, the sequence restarts from the power-on delay and group 0.
- R12: A groupDone pulse sampled on the edge that ends the start cycle is ignored. The current group then times out instead of advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency CLK_HZ |
| rstN | input | 1 | Active-low synchronous reset of the sequencer |
| suppliesOk | input | 1 | All converter supplies valid |
| sysrefOk | input | 1 | Converter system reference clock is running |
| groupDone | input | 1 | One-cycle completion pulse from the register writer |
| convReset | output | 1 | Converter reset pin, active high |
| grpIdx | output | 3 | Index of the write group to issue |
| grpStart | output | 1 | One-cycle start strobe for the writer |
| seqDone | output | 1 | Whole sequence complete |
| seqFault | output | 1 | Sticky writer-timeout fault |

## Verification
The completion handshake and the timeout expiry can fall on the same clock edge. The bench provokes this by delaying the writer's reply by exactly the budget for one group. The design must treat that as an accepted completion: the next group starts on that edge and no fault appears. Replying one cycle later is judged the other way: seqFault must rise on the expiry edge, and no further start may follow.

// File: rtl/conv_boot_pkg.sv
package conv_boot_pkg;

  localparam int NUM_GRP      = 6;
  localparam int SETTLE_AFTER = 2;
  localparam int GRP_W        = $clog2(NUM_GRP);

  localparam longint unsigned PWRON_NS  = 64'd1_000_000;
  localparam longint unsigned RSTHI_NS  = 64'd1_000;
  localparam longint unsigned GAP_NS    = 64'd100;
  localparam longint unsigned SETTLE_NS = 64'd50_000_000;

  typedef enum logic [2:0] {
    DLY_PWRON,
    DLY_RST,
    DLY_GAP,
    DLY_SETTLE,
    DLY_TMO
  } dly_e;

  typedef struct packed {
    logic load;
    dly_e sel;
    logic grpClr;
    logic grpInc;
  } tmrCmd_t;

  // Cycles needed to cover ns nanoseconds at hz, rounded up.
  function automatic longint unsigned cycFor(longint unsigned ns, longint unsigned hz);
    return (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

endpackage

// File: rtl/conv_boot_timer.sv
module conv_boot_timer
  import conv_boot_pkg::*;
#(
  parameter longint unsigned CLK_HZ  = 200_000_000,
  parameter longint unsigned TMO_CYC = 4096
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCmd_t          cmd,
  output logic             tZero,
  output logic             grpLast,
  output logic             grpSettle,
  output logic [GRP_W-1:0] grp
);

  localparam longint unsigned PWR_CYC = cycFor(PWRON_NS, CLK_HZ);
  localparam longint unsigned RST_CYC = cycFor(RSTHI_NS, CLK_HZ);
  localparam longint unsigned GAP_CYC = cycFor(GAP_NS, CLK_HZ);
  localparam longint unsigned STL_CYC = cycFor(SETTLE_NS, CLK_HZ);
  localparam longint unsigned MAX_A   = (PWR_CYC > STL_CYC) ? PWR_CYC : STL_CYC;
  localparam longint unsigned MAX_C   = (MAX_A > TMO_CYC) ? MAX_A : TMO_CYC;
  localparam int              CW      = $clog2(MAX_C + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] loadVal;

  always_comb begin
    case (cmd.sel)
      DLY_PWRON:  loadVal = CW'(PWR_CYC);
      DLY_RST:    loadVal = CW'(RST_CYC);
      DLY_GAP:    loadVal = CW'(GAP_CYC);
      DLY_SETTLE: loadVal = CW'(STL_CYC);
      default:    loadVal = CW'(TMO_CYC);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (cmd.load)    cnt <= loadVal;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            grp <= '0;
    else if (cmd.grpClr)  grp <= '0;
    else if (cmd.grpInc)  grp <= grp + 1'b1;
  end

  assign tZero     = (cnt == '0);
  assign grpLast   = (grp == GRP_W'(NUM_GRP - 1));
  assign grpSettle = (grp == GRP_W'(SETTLE_AFTER));

  // R6: the group index never leaves the defined range.
  a_r6_grp_range: assert property (@(posedge clk) disable iff (!rstN)
    grp <= GRP_W'(NUM_GRP - 1));

  // R7: a running delay only counts down by one per cycle when not reloaded.
  a_r7_cnt_monotone: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && cnt != '0) |=> (cnt < $past(cnt)));

endmodule

// File: rtl/conv_boot_ctrl.sv
module conv_boot_ctrl
  import conv_boot_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    suppliesOk,
  input  logic    sysrefOk,
  input  logic    groupDone,
  input  logic    tZero,
  input  logic    grpLast,
  input  logic    grpSettle,
  output tmrCmd_t cmd,
  output logic    convReset,
  output logic    grpStart,
  output logic    seqDone,
  output logic    seqFault
);

  typedef enum logic [3:0] {
    S_IDLE, S_PWRON, S_RSTHI, S_GAP, S_ISSUE, S_WAIT, S_SETTLE, S_DONE, S_FAULT
  } state_e;

  state_e state, nextState;
  logic   faultQ;

  always_comb begin
    nextState  = state;
    cmd.load   = 1'b0;
    cmd.sel    = DLY_TMO;
    cmd.grpClr = 1'b0;
    cmd.grpInc = 1'b0;
    if (!suppliesOk) begin
      nextState = S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (!faultQ) begin
          nextState  = S_PWRON;
          cmd.load   = 1'b1;
          cmd.sel    = DLY_PWRON;
          cmd.grpClr = 1'b1;
        end
        S_PWRON: if (tZero && sysrefOk) begin
          nextState = S_RSTHI;
          cmd.load  = 1'b1;
          cmd.sel   = DLY_RST;
        end
        S_RSTHI: if (tZero) begin
          nextState = S_GAP;
          cmd.load  = 1'b1;
          cmd.sel   = DLY_GAP;
        end
        S_GAP: if (tZero) begin
          nextState = S_ISSUE;
          cmd.load  = 1'b1;
          cmd.sel   = DLY_TMO;
        end
        S_ISSUE: nextState = S_WAIT;
        S_WAIT: begin
          if (groupDone) begin
            if (grpLast) begin
              nextState = S_DONE;
            end else begin
              cmd.grpInc = 1'b1;
              cmd.load   = 1'b1;
              if (grpSettle) begin
                nextState = S_SETTLE;
                cmd.sel   = DLY_SETTLE;
              end else begin
                nextState = S_ISSUE;
                cmd.sel   = DLY_TMO;
              end
            end
          end else if (tZero) begin
            nextState = S_FAULT;
          end
        end
        S_SETTLE: if (tZero) begin
          nextState = S_ISSUE;
          cmd.load  = 1'b1;
          cmd.sel   = DLY_TMO;
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      faultQ <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_WAIT && nextState == S_FAULT) faultQ <= 1'b1;
    end
  end

  assign convReset = (state == S_RSTHI);
  assign grpStart  = (state == S_ISSUE);
  assign seqDone   = (state == S_DONE);
  assign seqFault  = faultQ;

  // R5: reset only rises after the reference clock was seen running.
  a_r5_sysref_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convReset) |-> $past(sysrefOk));

  // R6: each start strobe lasts exactly one cycle.
  a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    grpStart |=> !grpStart);

  // R8: reset is never driven once the sequence is complete.
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> !convReset);

  // R10: the fault flag is sticky and blocks further activity.
  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    seqFault |=> seqFault);
  a_r10_fault_quiet: assert property (@(posedge clk) disable iff (!rstN)
    seqFault |-> (!grpStart && !convReset));

  // R11: a supply drop forces all sequencing outputs low on the next cycle.
  a_r11_supply_drop: assert property (@(posedge clk) disable iff (!rstN)
    !suppliesOk |=> (!convReset && !grpStart && !seqDone));

endmodule

// File: rtl/conv_boot_seq.sv
module conv_boot_seq
  import conv_boot_pkg::*;
#(
  parameter longint unsigned CLK_HZ  = 200_000_000,
  parameter longint unsigned TMO_CYC = 4096
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             suppliesOk,
  input  logic             sysrefOk,
  input  logic             groupDone,
  output logic             convReset,
  output logic [GRP_W-1:0] grpIdx,
  output logic             grpStart,
  output logic             seqDone,
  output logic             seqFault
);

  tmrCmd_t cmd;
  logic    tZero;
  logic    grpLast;
  logic    grpSettle;

  conv_boot_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .suppliesOk (suppliesOk),
    .sysrefOk   (sysrefOk),
    .groupDone  (groupDone),
    .tZero      (tZero),
    .grpLast    (grpLast),
    .grpSettle  (grpSettle),
    .cmd        (cmd),
    .convReset  (convReset),
    .grpStart   (grpStart),
    .seqDone    (seqDone),
    .seqFault   (seqFault)
  );

  conv_boot_timer #(
    .CLK_HZ  (CLK_HZ),
    .TMO_CYC (TMO_CYC)
  ) u_timer (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .tZero     (tZero),
    .grpLast   (grpLast),
    .grpSettle (grpSettle),
    .grp       (grpIdx)
  );

endmodule

// File: tb/sim_conv_boot_seq.sv
`timescale 1ns/1ps
module sim_conv_boot_seq;

  localparam longint unsigned HZ  = 1_000_000;
  localparam longint unsigned TMO = 8;
  localparam int NPWR = int'((64'd1_000_000 * HZ + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int NRST = int'((64'd1_000 * HZ + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int NGAP = int'((64'd100 * HZ + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int NSTL = int'((64'd50_000_000 * HZ + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int NTMO = int'(TMO);

  logic       clk = 1'b0;
  logic       rstN, suppliesOk, sysrefOk, groupDone;
  logic       convReset, grpStart, seqDone, seqFault;
  logic [2:0] grpIdx;

  conv_boot_seq #(.CLK_HZ(HZ), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rstN(rstN), .suppliesOk(suppliesOk), .sysrefOk(sysrefOk),
    .groupDone(groupDone), .convReset(convReset), .grpIdx(grpIdx),
    .grpStart(grpStart), .seqDone(seqDone), .seqFault(seqFault)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int expQ[$];
  int startCount = 0, startCyc = 0, riseCount = 0, riseCyc = 0;
  int fallCount = 0, fallCyc = 0, faultCyc = -1, lastDone = 0, handled = 0;
  logic prevStart = 1'b0, prevRst = 1'b0, prevFault = 1'b0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Monitor: pops expected group indices and records edge cycles.
  always @(negedge clk) begin
    if (grpStart && !prevStart) begin
      startCyc = cyc;
      if (expQ.size() == 0) begin
        check(1'b0, "R6 unexpected start", int'(grpIdx), -1);
      end else begin
        int e;
        e = expQ.pop_front();
        check(int'(grpIdx) == e, "R6 group order", int'(grpIdx), e);
      end
      startCount++;
    end
    if (convReset && !prevRst) begin riseCyc = cyc; riseCount++; end
    if (!convReset && prevRst) begin fallCyc = cyc; fallCount++; end
    if (seqFault && !prevFault) faultCyc = cyc;
    prevStart = grpStart;
    prevRst   = convReset;
    prevFault = seqFault;
  end

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finishRun();
  end

  task automatic waitStart();
    int target;
    target = handled + 1;
    wait (startCount >= target);
    handled = target;
  endtask

  // Driver side of the writer: reply d cycles after the start was observed.
  task automatic serve(input int d);
    repeat (d) @(negedge clk);
    groupDone = 1'b1;
    lastDone  = cyc + 1;
    @(negedge clk);
    groupDone = 1'b0;
  endtask

  task automatic powerUpPulse(input string tag, input int c0, input bit checkPwr);
    int r, f;
    r = riseCount; f = fallCount;
    wait (riseCount == r + 1);
    if (checkPwr) check(riseCyc == c0 + 1 + NPWR + 1, "R2 power-on delay", riseCyc - c0 - 1, NPWR + 1);
    wait (fallCount == f + 1);
    check(fallCyc - riseCyc == NRST + 1, {"R3 reset width ", tag}, fallCyc - riseCyc, NRST + 1);
  endtask

  initial begin
    int c0;
    int dly[6];
    rstN = 1'b0; suppliesOk = 1'b0; sysrefOk = 1'b0; groupDone = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!convReset && !grpStart && !seqDone && !seqFault, "R1 reset state",
          {convReset, grpStart, seqDone, seqFault}, 0);

    // Scenario A: reference clock late, full sequence
    for (int g = 0; g < 6; g++) expQ.push_back(g);
    suppliesOk = 1'b1;
    repeat (1500) @(negedge clk);
    check(!convReset && riseCount == 0, "R5 held without sysref", riseCount, 0);
    c0 = cyc;
    sysrefOk = 1'b1;
    powerUpPulse("A", c0, 1'b0);
    check(riseCyc == c0 + 1, "R5 rise on sysref edge", riseCyc, c0 + 1);
    dly = '{1, NTMO, 3, 2, 5, 1};
    for (int g = 0; g < 6; g++) begin
      waitStart();
      if (g == 0)
        check(startCyc - fallCyc == NGAP + 1, "R4 gap before first start", startCyc - fallCyc, NGAP + 1);
      else if (g == 3)
        check(startCyc - lastDone == NSTL + 1, "R7 settle pause", startCyc - lastDone, NSTL + 1);
      else
        check(startCyc == lastDone, "R7 back-to-back start", startCyc - lastDone, 0);
      serve(dly[g]);
    end
    check(seqDone && !convReset, "R8 done flag", {seqDone, convReset}, 2);
    check(!seqFault, "R9 reply on expiry edge accepted", seqFault, 0);
    repeat (20) @(negedge clk);
    check(startCount == 6 && expQ.size() == 0, "R6 six groups", startCount, 6);
    check(seqDone, "R8 done holds", seqDone, 1);
    suppliesOk = 1'b0;
    @(negedge clk);
    check(!seqDone && !convReset, "R11 drop clears done", {seqDone, convReset}, 0);

    // Scenario B: restart, then drop supplies during a group
    expQ.delete();
    expQ.push_back(0); expQ.push_back(1);
    repeat (5) @(negedge clk);
    c0 = cyc;
    suppliesOk = 1'b1;
    powerUpPulse("B", c0, 1'b1);
    waitStart();
    check(startCyc - fallCyc == NGAP + 1, "R4 gap after restart", startCyc - fallCyc, NGAP + 1);
    serve(2);
    waitStart();
    suppliesOk = 1'b0;
    @(negedge clk);
    check(!grpStart && !convReset && !seqDone, "R11 drop mid group", {grpStart, convReset, seqDone}, 0);
    repeat (4) @(negedge clk);
    check(startCount == 8 && expQ.size() == 0, "R11 no start after drop", startCount, 8);

    // Scenario C: reply one cycle too late
    expQ.push_back(0); expQ.push_back(1);
    suppliesOk = 1'b1;
    powerUpPulse("C", 0, 1'b0);
    waitStart();
    serve(1);
    waitStart();
    c0 = startCyc;
    serve(NTMO + 1);
    check(seqFault && faultCyc == c0 + NTMO + 1, "R9 fault on expiry edge", faultCyc - c0, NTMO + 1);
    suppliesOk = 1'b0;
    repeat (3) @(negedge clk);
    suppliesOk = 1'b1;
    c0 = riseCount;
    repeat (1300) @(negedge clk);
    check(seqFault && startCount == 10 && riseCount == c0, "R10 fault blocks restart", startCount, 10);

    // Scenario D: reset clears fault; reply inside the start cycle is ignored
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!seqFault, "R1 fault cleared by rstN", seqFault, 0);
    expQ.push_back(0);
    powerUpPulse("D", 0, 1'b0);
    waitStart();
    c0 = startCyc;
    serve(0);
    repeat (NTMO + 4) @(negedge clk);
    check(seqFault && faultCyc == c0 + NTMO + 1, "R12 early reply ignored", faultCyc - c0, NTMO + 1);
    check(startCount == 11, "R12 no advance", startCount, 11);

    finishRun();
  end

endmodule